// File: doc/BRIEF.md
# Watchdog Timer with Delayed Reset

This block is a supervision timer that runs on the system clock and watches for software that has stopped making progress. An internal divider counts up from its last restart. A two-bit select picks which of four power-of-two lengths ends the count. When the selected length is reached, the block raises a sticky time-out flag. If the interrupt enable is set, that flag also drives an interrupt request. The divider then starts over on its own.

A time-out also opens a grace window of a fixed number of clocks, 512 by default. If software writes the clear command before the window ends, the pending reset is dropped and the divider restarts. If the window runs out while reset generation is enabled, the block emits a system reset pulse one clock long. In the same clock it records the reset cause in a flag. That cause flag is kept on the power-on reset domain, so the system reset it triggers does not erase it. Software or a power-on reset clears it. The clear command reads back as a bit that hardware drops again after one clock.

Top module: `wdt_delayed_reset`

## Requirements
- R1: After the system reset and the power-on reset, `to_flag`, `irq`, `wdt_rst`, `clr_bit` and `cause_flag` all read 0.
- R2: The time-out period is 2^(TAP_LO_LOG + TAP_STEP*tsel) clocks, with `tsel` taken as an unsigned value 0 to 3. `to_flag` rises exactly one period of clocks after the restart caused by a clear command.
- R3: `to_flag` stays set until a clock with `to_ack` high clears it, and a new time-out in that same clock wins over the acknowledge. `irq` is high exactly when `to_flag` and `int_en` are both high.
- R4: With `rst_en` high and no clear command, `wdt_rst` rises exactly GRACE_CLKS clocks after the `to_flag` rise that opened the grace window. It is high for exactly one clock.
- R5: A clear command taken during the grace window cancels the pending reset, so no `wdt_rst` pulse comes from that window.
- R6: With `rst_en` low, the grace window ends without a `wdt_rst` pulse, and `cause_flag` does not change.
- R7: A clock with `clr_wr` high sets `clr_bit`. In the next clock, `clr_bit` restarts the divider and the grace window, and hardware drops `clr_bit` back to 0.
- R8: `cause_flag` is set in the clock of every `wdt_rst` pulse. It keeps its value through `rst`, and only `cause_clr` or `por` clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high system reset |
| por | input | 1 | Synchronous active-high power-on reset; clears only the cause flag |
| tsel | input | 2 | Time-out length select |
| int_en | input | 1 | Interrupt request enable |
| rst_en | input | 1 | System reset generation enable |
| clr_wr | input | 1 | Write strobe that sets the clear command bit |
| to_ack | input | 1 | Clears the time-out flag |
| cause_clr | input | 1 | Clears the reset-cause flag |
| clr_bit | output | 1 | Clear command bit as software reads it (self-clearing) |
| to_flag | output | 1 | Sticky time-out flag |
| irq | output | 1 | Interrupt request |
| wdt_rst | output | 1 | One-clock system reset pulse |
| cause_flag | output | 1 | Reset-cause flag, kept through the system reset |

## Verification
The assertions check on every cycle the local rules:
- the time-out flag holds until it is acknowledged;
- the reset pulse is one clock wide and follows a clock with reset enabled;
- a clear command suppresses the pulse in the following clock;
- the cause flag is set whenever the pulse is high.

Only the directed scenarios can show the behaviour that spans long stretches of time:
- the exact time-out length for each select value;
- the exact 512-clock gap from flag to reset;
- a mid-window clear cancelling a reset that would have come hundreds of clocks later;
- the cause flag surviving a system reset and being cleared by power-on reset.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    // Decoded time-out select; the numeric value scales the tap exponent.
    typedef enum logic [1:0] {
        TSEL_SHORTEST = 2'd0,
        TSEL_SHORT    = 2'd1,
        TSEL_LONG     = 2'd2,
        TSEL_LONGEST  = 2'd3
    } tsel_e;

    // Events passed from the divider and grace logic to the top.
    typedef struct packed {
        logic expire;   // selected tap reached this clock
        logic fire;     // grace window ended with reset enabled
    } wdt_ev_t;

    // Exponent of the time-out period for a given select.
    function automatic int unsigned tap_exp(input tsel_e sel,
                                            input int unsigned lo,
                                            input int unsigned step);
        return lo + step * int'(sel);
    endfunction

endpackage

// File: rtl/wdt_divider.sv
module wdt_divider
    import wdt_pkg::*;
#(
    parameter int unsigned TAP_LO_LOG = 14,
    parameter int unsigned TAP_STEP   = 2,
    parameter int unsigned CNT_W      = TAP_LO_LOG + 3 * TAP_STEP
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       restart,
    input  tsel_e      tsel,
    output logic       expire
);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W:0]   span;
    logic [CNT_W-1:0] mask;

    // Mask of the low bits that must all be ones at the end of a period.
    always_comb begin
        span   = ({{CNT_W{1'b0}}, 1'b1} << tap_exp(tsel, TAP_LO_LOG, TAP_STEP)) - 1'b1;
        mask   = span[CNT_W-1:0];
        expire = ((cnt & mask) == mask) && !restart;
    end

    always_ff @(posedge clk) begin
        if (rst || restart || expire)
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end

endmodule

// File: rtl/wdt_grace.sv
module wdt_grace #(
    parameter int unsigned GRACE_CLKS = 512,
    parameter int unsigned GW         = $clog2(GRACE_CLKS)
) (
    input  logic clk,
    input  logic rst,
    input  logic restart,
    input  logic expire,
    input  logic rst_en,
    output logic fire,
    output logic wdt_rst
);

    logic          act;
    logic [GW-1:0] gcnt;
    logic          last;

    assign last = (gcnt == GW'(GRACE_CLKS - 1));
    assign fire = act && last && rst_en && !restart;

    always_ff @(posedge clk) begin
        if (rst) begin
            act     <= 1'b0;
            gcnt    <= '0;
            wdt_rst <= 1'b0;
        end else begin
            wdt_rst <= fire;
            if (restart) begin
                act  <= 1'b0;
                gcnt <= '0;
            end else if (act) begin
                if (last) begin
                    act  <= 1'b0;
                    gcnt <= '0;
                end else begin
                    gcnt <= gcnt + 1'b1;
                end
            end else if (expire) begin
                act  <= 1'b1;
                gcnt <= '0;
            end
        end
    end

    // R5: a clear command leaves no reset pulse behind it
    a_r5_clear_cancels: assert property (@(posedge clk) disable iff (rst)
        restart |=> !wdt_rst);

    // R6: a pulse is only produced while reset generation was enabled
    a_r6_needs_enable: assert property (@(posedge clk) disable iff (rst)
        wdt_rst |-> $past(rst_en));

    // R4: the reset pulse lasts a single clock
    a_r4_single_pulse: assert property (@(posedge clk) disable iff (rst)
        wdt_rst |=> !wdt_rst);

endmodule

// File: rtl/wdt_cause.sv
module wdt_cause (
    input  logic clk,
    input  logic por,
    input  logic set,
    input  logic clr,
    output logic flag
);

    // Lives on the power-on domain so the system reset does not erase it.
    always_ff @(posedge clk) begin
        if (por)
            flag <= 1'b0;
        else if (set)
            flag <= 1'b1;
        else if (clr)
            flag <= 1'b0;
    end

    // R8: a watchdog reset always leaves the cause recorded
    a_r8_set_recorded: assert property (@(posedge clk) disable iff (por)
        set |=> flag);

endmodule

// File: rtl/wdt_delayed_reset.sv
module wdt_delayed_reset
    import wdt_pkg::*;
#(
    parameter int unsigned TAP_LO_LOG = 14,
    parameter int unsigned TAP_STEP   = 2,
    parameter int unsigned GRACE_CLKS = 512
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       por,
    input  logic [1:0] tsel,
    input  logic       int_en,
    input  logic       rst_en,
    input  logic       clr_wr,
    input  logic       to_ack,
    input  logic       cause_clr,
    output logic       clr_bit,
    output logic       to_flag,
    output logic       irq,
    output logic       wdt_rst,
    output logic       cause_flag
);

    localparam int unsigned CNT_W = TAP_LO_LOG + 3 * TAP_STEP;

    wdt_ev_t ev;
    logic    div_restart;

    // The divider also starts over when the grace window fires a reset.
    assign div_restart = clr_bit || ev.fire;

    wdt_divider #(
        .TAP_LO_LOG (TAP_LO_LOG),
        .TAP_STEP   (TAP_STEP),
        .CNT_W      (CNT_W)
    ) u_div (
        .clk     (clk),
        .rst     (rst),
        .restart (div_restart),
        .tsel    (tsel_e'(tsel)),
        .expire  (ev.expire)
    );

    wdt_grace #(
        .GRACE_CLKS (GRACE_CLKS)
    ) u_grace (
        .clk     (clk),
        .rst     (rst),
        .restart (clr_bit),
        .expire  (ev.expire),
        .rst_en  (rst_en),
        .fire    (ev.fire),
        .wdt_rst (wdt_rst)
    );

    wdt_cause u_cause (
        .clk  (clk),
        .por  (por),
        .set  (ev.fire),
        .clr  (cause_clr),
        .flag (cause_flag)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            clr_bit <= 1'b0;
            to_flag <= 1'b0;
        end else begin
            clr_bit <= clr_wr;
            if (ev.expire)
                to_flag <= 1'b1;
            else if (to_ack)
                to_flag <= 1'b0;
        end
    end

    assign irq = to_flag && int_en;

    // R3: the time-out flag holds until acknowledged
    a_r3_flag_sticky: assert property (@(posedge clk) disable iff (rst)
        (to_flag && !to_ack) |=> to_flag);

    // R8: the cause flag is high during every reset pulse
    a_r8_cause_with_pulse: assert property (@(posedge clk) disable iff (rst || por)
        wdt_rst |-> cause_flag);

endmodule

// File: tb/tb_wdt_delayed_reset.sv
module tb_wdt_delayed_reset;

    localparam int CLK_PERIOD = 10;
    localparam int LO         = 4;
    localparam int STEP       = 1;
    localparam int GRACE      = 512;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       por = 1'b1;
    logic [1:0] tsel = 2'd0;
    logic       int_en = 1'b0;
    logic       rst_en = 1'b0;
    logic       clr_wr = 1'b0;
    logic       to_ack = 1'b0;
    logic       cause_clr = 1'b0;
    logic       clr_bit, to_flag, irq, wdt_rst, cause_flag;

    int nchecks = 0;
    int nfail   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    wdt_delayed_reset #(
        .TAP_LO_LOG (LO),
        .TAP_STEP   (STEP),
        .GRACE_CLKS (GRACE)
    ) dut (
        .clk        (clk),
        .rst        (rst),
        .por        (por),
        .tsel       (tsel),
        .int_en     (int_en),
        .rst_en     (rst_en),
        .clr_wr     (clr_wr),
        .to_ack     (to_ack),
        .cause_clr  (cause_clr),
        .clr_bit    (clr_bit),
        .to_flag    (to_flag),
        .irq        (irq),
        .wdt_rst    (wdt_rst),
        .cause_flag (cause_flag)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        nchecks++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("  TB_RESULT checks=%0d failures=%0d", nchecks, nfail);
    endtask

    // Clear command with acknowledge; returns just after the restart edge.
    task automatic do_clear();
        @(negedge clk); clr_wr = 1'b1; to_ack = 1'b1;
        @(negedge clk); chk("R7", "clr_bit set", int'(clr_bit), 1); clr_wr = 1'b0;
        @(negedge clk); chk("R7", "clr_bit self-clear", int'(clr_bit), 0); to_ack = 1'b0;
        chk("R3", "flag cleared by ack", int'(to_flag), 0);
    endtask

    task automatic count_to_flag(output int n);
        n = 0;
        while (!to_flag && n < 5000) begin
            @(negedge clk); n++;
        end
    endtask

    task automatic count_to_pulse(output int m);
        m = 0;
        while (!wdt_rst && m < 5000) begin
            @(negedge clk); m++;
        end
    endtask

    task automatic t_reset_state();
        chk("R1", "to_flag", int'(to_flag), 0);
        chk("R1", "irq", int'(irq), 0);
        chk("R1", "wdt_rst", int'(wdt_rst), 0);
        chk("R1", "clr_bit", int'(clr_bit), 0);
        chk("R1", "cause_flag", int'(cause_flag), 0);
    endtask

    task automatic t_periods();
        int n;
        rst_en = 1'b0;
        for (int s = 0; s < 4; s++) begin
            tsel = 2'(s);
            do_clear();
            count_to_flag(n);
            chk("R2", $sformatf("period tsel=%0d", s), n, 1 << (LO + STEP * s));
        end
    endtask

    task automatic t_irq();
        int n;
        tsel = 2'd0; int_en = 1'b0;
        do_clear();
        count_to_flag(n);
        chk("R3", "irq masked", int'(irq), 0);
        int_en = 1'b1; #1;
        chk("R3", "irq enabled", int'(irq), 1);
        repeat (40) @(negedge clk);
        chk("R3", "flag sticky", int'(to_flag), 1);
        to_ack = 1'b1;
        @(negedge clk); to_ack = 1'b0;
        chk("R3", "flag after ack", int'(to_flag), 0);
        chk("R3", "irq after ack", int'(irq), 0);
    endtask

    task automatic t_delayed_reset();
        int n, m;
        tsel = 2'd0; rst_en = 1'b1;
        do_clear();
        count_to_flag(n);
        count_to_pulse(m);
        chk("R4", "flag to reset gap", m, GRACE);
        chk("R8", "cause with pulse", int'(cause_flag), 1);
        @(negedge clk);
        rst_en = 1'b0;
        chk("R4", "pulse width", int'(wdt_rst), 0);
        // R8: system reset keeps the cause
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        chk("R8", "cause survives rst", int'(cause_flag), 1);
        chk("R1", "flag cleared by rst", int'(to_flag), 0);
        cause_clr = 1'b1;
        @(negedge clk); cause_clr = 1'b0;
        chk("R8", "cause cleared by software", int'(cause_flag), 0);
        // second reset, then power-on reset clears the cause
        rst_en = 1'b1;
        do_clear();
        count_to_flag(n);
        count_to_pulse(m);
        chk("R4", "second gap", m, GRACE);
        @(negedge clk); rst_en = 1'b0;
        chk("R8", "cause set again", int'(cause_flag), 1);
        por = 1'b1;
        @(negedge clk); por = 1'b0;
        chk("R8", "cause cleared by por", int'(cause_flag), 0);
    endtask

    task automatic t_cancel();
        int n, pulses;
        tsel = 2'd3; rst_en = 1'b1;
        do_clear();
        count_to_flag(n);
        pulses = 0;
        for (int i = 0; i < 300; i++) begin
            @(negedge clk); if (wdt_rst) pulses++;
        end
        do_clear();
        for (int i = 0; i < 500; i++) begin
            @(negedge clk); if (wdt_rst) pulses++;
        end
        chk("R5", "pulses after mid-window clear", pulses, 0);
        rst_en = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_disabled();
        int pulses;
        tsel = 2'd0; rst_en = 1'b0;
        do_clear();
        pulses = 0;
        for (int i = 0; i < 1200; i++) begin
            @(negedge clk); if (wdt_rst) pulses++;
        end
        chk("R6", "pulses with reset disabled", pulses, 0);
        chk("R6", "cause unchanged", int'(cause_flag), 0);
        chk("R6", "time-out still flagged", int'(to_flag), 1);
    endtask

    initial begin : wd
        repeat (60000) @(posedge clk);
        nchecks++; nfail++;
        $display("FAIL watchdog expired actual=running expected=done");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0; por = 1'b0;
        @(negedge clk);
        t_reset_state();
        t_periods();
        t_irq();
        t_delayed_reset();
        t_cancel();
        t_disabled();
        summary();
        $finish;
    end

endmodule